// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control engine of a successive-approximation analog-to-digital converter. A start request captures a sampling length in clock cycles. The block then holds its track output high for that many cycles so that an external sample-and-hold can follow the input. After that it runs a binary search on a trial code that it presents to an external DAC. Each cycle it reads a one-bit comparator that reports whether the held input is at or above the trial level, and it settles one bit of the code, starting from the most significant bit.

When the least significant bit has been settled, the finished word is copied into an output register that is separate from the working register. A single-cycle done strobe marks the copy. The output keeps that value until the next conversion finishes. The resolution and the width of the sampling-length field are parameters. The converter and its analog parts sit outside this block.

Top module: `sar_sequencer`

## Requirements
- R1: A start request seen while idle begins a conversion. From the next cycle track_o and busy_o are high and trial_o is all zeros.
- R2: track_o stays high for exactly L consecutive cycles, where L is the value of samp_len_i captured with the accepted start. samp_len_i is ignored at all other times.
- R3: A captured sampling length of 0 is treated as 1 cycle.
- R4: In the first cycle after the sampling phase, trial_o has only its most significant bit set, which is half of full scale.
- R5: During the search each cycle settles one bit, from the MSB down. If cmp_i is high the bit under test stays 1, otherwise it becomes 0, and in the same step the next lower bit is set to 1. Bits below the bit under test are 0, so the search takes exactly RES_BITS cycles.
- R6: The clock edge that settles the LSB loads code_o with the completed word and raises done_o for exactly one cycle. With the comparator high when the input is at or above the trial level, code_o equals the input level. code_o changes at no other time.
- R7: A start request that arrives while busy_o is high is ignored. It neither lengthens nor restarts the sampling phase or the search.
- R8: track_o is high only during the sampling phase. busy_o is high from the cycle after an accepted start until the cycle done_o is raised, and busy_o is low while done_o is high.
- R9: A start request in the cycle done_o is high is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled on the clock edge |
| samp_len_i | input | SAMP_W | Sampling length in cycles, captured with an accepted start |
| cmp_i | input | 1 | Comparator: high when the held input is at or above trial_o |
| track_o | output | 1 | Sample-and-hold control, high while sampling |
| trial_o | output | RES_BITS | Trial code for the external DAC |
| busy_o | output | 1 | Conversion in progress |
| code_o | output | RES_BITS | Last completed conversion result |
| done_o | output | 1 | One-cycle strobe that marks an update of code_o |

## Verification
Call the clock edge that accepts a start E0, and the captured sampling length L (or 1 when it is 0). track_o is high from just after E0 until edge E_L. trial_o shows the MSB-only code just after E_L and one new partial code after each of the next RES_BITS edges. done_o and the new code_o appear just after edge E_(L+RES_BITS). The bench drives inputs and samples outputs on falling clock edges and walks these cycles one by one. It counts the track cycles, compares each trial code with the value expected from the input level and the bits already settled, and checks done_o and code_o at the computed edge and again one cycle later.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_TRACK  = 2'd1,
    PH_SEARCH = 2'd2
  } phase_e;
endpackage

// File: rtl/sarseq_phase_ctrl.sv
module sarseq_phase_ctrl
  import sarseq_pkg::*;
#(
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SAMP_W-1:0] samp_len_i,
  input  logic              last_bit_i,
  output logic              accept_o,
  output logic              seed_o,
  output logic              step_o,
  output logic              finish_o,
  output logic              track_o,
  output logic              busy_o
);
  localparam logic [SAMP_W-1:0] LEN_ONE = SAMP_W'(1);

  phase_e            phase_q, phase_d;
  logic [SAMP_W-1:0] cnt_q;
  logic [SAMP_W-1:0] len_eff;

  // a zero length is raised to one cycle
  assign len_eff = (samp_len_i == '0) ? LEN_ONE : samp_len_i;

  always_comb begin
    accept_o = (phase_q == PH_IDLE) && start_i;
    seed_o   = (phase_q == PH_TRACK) && (cnt_q == '0);
    step_o   = (phase_q == PH_SEARCH);
    finish_o = step_o && last_bit_i;
    phase_d  = phase_q;
    if (accept_o)      phase_d = PH_TRACK;
    else if (seed_o)   phase_d = PH_SEARCH;
    else if (finish_o) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      track_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      track_o <= (phase_d == PH_TRACK);
      busy_o  <= (phase_d != PH_IDLE);
      if (accept_o)
        cnt_q <= len_eff - LEN_ONE;
      else if (phase_q == PH_TRACK && cnt_q != '0)
        cnt_q <= cnt_q - LEN_ONE;
    end
  end
endmodule

// File: rtl/sarseq_search_reg.sv
module sarseq_search_reg #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic                seed_i,
  input  logic                step_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] work_o,
  output logic [RES_BITS-1:0] sel_o,
  output logic                last_o
);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sel_dn;
  assign sel_dn = sel_o >> 1;
  assign last_o = sel_o[0];

  // pointer to the bit under test, one-hot
  always_ff @(posedge clk) begin
    if (rst || clear_i) sel_o <= '0;
    else if (seed_i)    sel_o <= MSB_ONLY;
    else if (step_i)    sel_o <= sel_dn;
  end

  // one decision cell per bit of the working register
  for (genvar b = 0; b < RES_BITS; b++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst || clear_i)   work_o[b] <= 1'b0;
      else if (seed_i)      work_o[b] <= MSB_ONLY[b];
      else if (step_i) begin
        if (sel_o[b])       work_o[b] <= cmp_i;
        else if (sel_dn[b]) work_o[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sarseq_result_reg.sv
module sarseq_result_reg #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                finish_i,
  input  logic                cmp_i,
  input  logic [RES_BITS-1:0] work_i,
  input  logic [RES_BITS-1:0] sel_i,
  output logic [RES_BITS-1:0] code_o,
  output logic                done_o
);
  logic [RES_BITS-1:0] settled;
  assign settled = (work_i & ~sel_i) | (cmp_i ? sel_i : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) code_o <= settled;
    end
  end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES_BITS = 10,
  parameter int SAMP_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SAMP_W-1:0]   samp_len_i,
  input  logic                cmp_i,
  output logic                track_o,
  output logic [RES_BITS-1:0] trial_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] code_o,
  output logic                done_o
);
  logic                accept, seed, step, finish, last_bit;
  logic [RES_BITS-1:0] work, bit_sel;

  sarseq_phase_ctrl #(.SAMP_W(SAMP_W)) u_phase (
    .clk(clk), .rst(rst), .start_i(start_i), .samp_len_i(samp_len_i),
    .last_bit_i(last_bit), .accept_o(accept), .seed_o(seed), .step_o(step),
    .finish_o(finish), .track_o(track_o), .busy_o(busy_o)
  );

  sarseq_search_reg #(.RES_BITS(RES_BITS)) u_search (
    .clk(clk), .rst(rst), .clear_i(accept), .seed_i(seed), .step_i(step),
    .cmp_i(cmp_i), .work_o(work), .sel_o(bit_sel), .last_o(last_bit)
  );

  sarseq_result_reg #(.RES_BITS(RES_BITS)) u_result (
    .clk(clk), .rst(rst), .finish_i(finish), .cmp_i(cmp_i), .work_i(work),
    .sel_i(bit_sel), .code_o(code_o), .done_o(done_o)
  );

  assign trial_o = work;
endmodule

// File: rtl/sarseq_checker.sv
module sarseq_checker #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         track_o,
  input logic         busy_o,
  input logic         done_o,
  input logic [N-1:0] code_o,
  input logic [N-1:0] trial_o,
  input logic [N-1:0] sel_i
);
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ONE      = N'(1);

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(track_o) |-> trial_o == MSB_ONLY);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(code_o));

  assert_track_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    track_o |-> busy_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_i));

  assert_low_bits_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !track_o) |-> ((trial_o & (sel_i - ONE)) == '0));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !track_o && start_i) |=> !track_o);
endmodule

bind sar_sequencer sarseq_checker #(.N(RES_BITS)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .track_o(track_o), .busy_o(busy_o),
  .done_o(done_o), .code_o(code_o), .trial_o(trial_o), .sel_i(bit_sel)
);

// File: tb/sar_sequencer_tb.sv
module sar_sequencer_tb;
  localparam int N  = 10;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [SW-1:0] samp_len_i = '0;
  logic          cmp_i;
  logic          track_o, busy_o, done_o;
  logic [N-1:0]  trial_o, code_o;
  int            vin = 0;
  int            n_cmp = 0;
  int            n_bad = 0;
  int            cyc = 0;
  bit            ended = 1'b0;

  always #2 clk = ~clk;

  // ideal comparator: high when input level is at or above the trial code
  assign cmp_i = (vin >= int'(trial_o));

  sar_sequencer #(.RES_BITS(N), .SAMP_W(SW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .samp_len_i(samp_len_i),
    .cmp_i(cmp_i), .track_o(track_o), .trial_o(trial_o), .busy_o(busy_o),
    .code_o(code_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  function automatic int exp_trial(input int v, input int i);
    return ((v >> (i + 1)) << (i + 1)) | (1 << i);
  endfunction

  // called at a falling edge; leaves the bench at the falling edge where done_o is due
  task automatic convert(input int v, input int len, input bit poke);
    int tcnt = 0;
    vin = v;
    start_i = 1'b1;
    samp_len_i = SW'(len);
    @(negedge clk);
    start_i = 1'b0;
    chk(track_o && busy_o, "R1 track/busy after start", int'(track_o), 1);
    chk(trial_o == '0, "R1 trial cleared", int'(trial_o), 0);
    chk(done_o == 1'b0, "R9 done low after restart", int'(done_o), 0);
    while (track_o && tcnt < 1000) begin
      tcnt++;
      if (poke) begin
        start_i = 1'b1;
        samp_len_i = SW'(200);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(tcnt == exp_len(len), (len == 0) ? "R3 zero length" : (poke ? "R7 track length" : "R2 track length"),
        tcnt, exp_len(len));
    chk(trial_o == N'(1 << (N - 1)), "R4 first trial MSB", int'(trial_o), 1 << (N - 1));
    for (int i = N - 1; i >= 0; i--) begin
      chk(int'(trial_o) == exp_trial(v, i), "R5 trial code", int'(trial_o), exp_trial(v, i));
      chk(!track_o && busy_o && !done_o, poke ? "R7 search undisturbed" : "R8 search flags",
          int'({track_o, busy_o, done_o}), 2);
      if (poke) start_i = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R6 done strobe", int'(done_o), 1);
    chk(int'(code_o) == v, "R6 code value", int'(code_o), v);
    chk(busy_o == 1'b0, "R8 busy low at done", int'(busy_o), 0);
  endtask

  task automatic after_done(input int v);
    samp_len_i = SW'(3);
    @(negedge clk);
    chk(done_o == 1'b0, "R6 done one cycle", int'(done_o), 0);
    chk(int'(code_o) == v, "R6 code held", int'(code_o), v);
    chk(!track_o && !busy_o, "R2 len change while idle ignored", int'(track_o), 0);
  endtask

  initial begin
    int seed = $urandom(32'h5EED);
    int v, l;
    repeat (5) @(negedge clk);
    chk(!track_o && !busy_o && !done_o, "R8 reset flags", int'({track_o, busy_o, done_o}), 0);
    chk(code_o == '0 && trial_o == '0, "R6 reset code", int'(code_o), 0);
    rst = 1'b0;
    @(negedge clk);

    convert(0, 1, 1'b0);            after_done(0);
    convert((1 << N) - 1, 0, 1'b0); after_done((1 << N) - 1);
    convert(1 << (N - 1), 4, 1'b0); after_done(1 << (N - 1));
    convert((1 << (N - 1)) - 1, 255, 1'b0); after_done((1 << (N - 1)) - 1);
    convert(341, 3, 1'b1);          after_done(341);
    // back-to-back: restart in the done cycle
    convert(700, 2, 1'b0);
    convert(5, 1, 1'b0);
    convert(1000, 0, 1'b1);         after_done(1000);

    for (int k = 0; k < 150; k++) begin
      v = int'($urandom_range((1 << N) - 1, 0));
      l = int'($urandom_range(9, 0));
      convert(v, l, ($urandom_range(3, 0) == 0));
      if ($urandom_range(1, 0) == 1) after_done(v);
    end
    if (seed == 0) n_cmp = n_cmp + 0;
    @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !ended) begin
      ended = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule